// File: doc/BRIEF.md
# Host Interrupt Enable Register

This block is an 8-bit control register on the local-CPU side of a host interface. Firmware uses it to decide which output-buffer-full (OBF) flags raise interrupt requests toward the host. It drives three request lines: two keyboard-style lines gated by the first buffer's flag, and one system-management line. The system-management line collects three sources. A direct mode lets an enable bit raise its request without the matching OBF flag.

An enable bit cannot be set by a single write. Firmware must first read the register and see that bit as 0. Only a later write of 1 then takes effect. Any write disarms every bit. An enable bit also clears itself when its OBF flag falls. For two of the system-management sources this happens only outside direct mode.

The top bit reports whether the serial interrupt stream is in quiet or continuous mode. It is loaded from the stop frame. Either host-side reset clears the whole register.

Top module: `hirq_ctl`

## Requirements
- R1: After `rst_n` is released, `rd_data` reads 0x00 and `hirq1`, `hirq12` and `smi` are low.
- R2: A write of 1 to an enable bit (bits 0 to 4) has no effect unless that bit was last read as 0 with no write in between.
- R3: After a read that returns an enable bit as 0, a write of 1 to that bit sets it. Any write clears the armed state of every bit.
- R4: Writing 0 to an enable bit clears it. Bit 5 (direct mode) is a plain read/write bit. Bit 6 always reads 0. Writes to bits 6 and 7 have no effect.
- R5: A pulse on `lpc_hw_rst` or `lpc_sw_rst` clears bits 0 to 5, bit 7, and every armed state.
- R6: A 1-to-0 transition of `obf1` clears bit 0 and bit 1 on the next clock edge.
- R7: A falling `obf2` clears bit 2, and a falling `obf3b` clears bit 4, but only while bit 5 is 0. A falling `obf3a` never clears bit 3.
- R8: `hirq1` equals bit 0 AND `obf1`. `hirq12` equals bit 1 AND `obf1`.
- R9: `smi` is the OR of three terms: bit 2 with `obf2`, bit 3 with `obf3a`, and bit 4 with `obf3b`. In each term the OBF flag is replaced by 1 while bit 5 is set.
- R10: A cycle with `stop_valid` high loads `stop_quiet` into bit 7 (1 = quiet, 0 = continuous).
- R11: When a clear condition and a set condition hit the same enable bit in the same cycle, the bit ends up 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low chip reset |
| lpc_hw_rst | input | 1 | Host-side hardware reset, synchronous, active high |
| lpc_sw_rst | input | 1 | Host-side software reset, synchronous, active high |
| rd_en | input | 1 | Local-CPU read strobe for this register |
| wr_en | input | 1 | Local-CPU write strobe for this register |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Register value: {quiet, 0, direct, en4..en0} |
| obf1 | input | 1 | Buffer 1 full flag |
| obf2 | input | 1 | Buffer 2 full flag |
| obf3a | input | 1 | Buffer 3A full flag |
| obf3b | input | 1 | Buffer 3B full flag |
| stop_valid | input | 1 | Stop frame mode indication valid |
| stop_quiet | input | 1 | Mode from stop frame, 1 = quiet |
| hirq1 | output | 1 | Host interrupt request 1 |
| hirq12 | output | 1 | Host interrupt request 12 |
| smi | output | 1 | System-management interrupt request |

## Verification
A wrong armed state stays hidden in `rd_data` until the next write. Once that write happens, it shows at once: a bit sets when it should not, or fails to set. A missed OBF-fall clear leaves the enable bit visible in `rd_data` one cycle after the fall. It also shows on the request line the next time that flag rises. Errors in direct-mode gating show on `smi` in the same cycle, because the request outputs are combinational from the register and the flags.

// File: rtl/hirq_pkg.sv
package hirq_pkg;
   localparam int NUM_EN    = 5;
   localparam int NUM_OBF   = 4;
   localparam int BIT_DIR   = 5;
   localparam int BIT_RSV   = 6;
   localparam int BIT_QUIET = 7;

   typedef enum logic [1:0] {ACLR_NONE, ACLR_ALWAYS, ACLR_UNLESS_DIRECT} aclr_e;

   // auto-clear policy of each enable bit
   function automatic aclr_e aclr_kind(input int idx);
      case (idx)
         0, 1:    return ACLR_ALWAYS;
         2, 4:    return ACLR_UNLESS_DIRECT;
         default: return ACLR_NONE;
      endcase
   endfunction

   // which OBF flag (index into {3b,3a,2,1}) belongs to each enable bit
   function automatic int obf_src(input int idx);
      case (idx)
         0, 1:    return 0;
         2:       return 1;
         3:       return 2;
         default: return 3;
      endcase
   endfunction
endpackage

// File: rtl/hirq_obf_edge.sv
module hirq_obf_edge #(
   parameter int N = 4
) (
   input  logic         clk,
   input  logic [N-1:0] obf,
   output logic [N-1:0] fall
);
   logic [N-1:0] obf_q;

   always_ff @(posedge clk) obf_q <= obf;

   assign fall = obf_q & ~obf;
endmodule

// File: rtl/hirq_en_bit.sv
module hirq_en_bit
   import hirq_pkg::*;
#(
   parameter aclr_e ACLR = ACLR_NONE
) (
   input  logic clk,
   input  logic rst_n,
   input  logic lpc_rst,
   input  logic rd_en,
   input  logic wr_en,
   input  logic wr_bit,
   input  logic obf_fall,
   input  logic direct,
   output logic en_q
);
   logic arm_q;
   logic aclr_hit;
   logic clr;
   logic set;

   generate
      if (ACLR == ACLR_ALWAYS) begin : g_always
         assign aclr_hit = obf_fall;
      end else if (ACLR == ACLR_UNLESS_DIRECT) begin : g_gated
         assign aclr_hit = obf_fall & ~direct;
      end else begin : g_none
         assign aclr_hit = 1'b0;
      end
   endgenerate

   assign clr = lpc_rst | (wr_en & ~wr_bit) | aclr_hit;
   assign set = wr_en & wr_bit & arm_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q  <= 1'b0;
         arm_q <= 1'b0;
      end else begin
         if (clr)      en_q <= 1'b0;
         else if (set) en_q <= 1'b1;
         if (lpc_rst || wr_en)   arm_q <= 1'b0;
         else if (rd_en && !en_q) arm_q <= 1'b1;
      end
   end

   // R2
   set_needs_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(en_q) |-> $past(wr_en && wr_bit && arm_q));
   // R4
   wr_zero_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_bit) |=> !en_q);
   // R11
   clear_beats_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (aclr_hit && wr_en && wr_bit) |=> !en_q);
endmodule

// File: rtl/hirq_mode_flag.sv
module hirq_mode_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic lpc_rst,
   input  logic stop_valid,
   input  logic stop_quiet,
   output logic quiet_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          quiet_q <= 1'b0;
      else if (lpc_rst)    quiet_q <= 1'b0;
      else if (stop_valid) quiet_q <= stop_quiet;
   end

   // R5
   quiet_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lpc_rst |=> !quiet_q);
endmodule

// File: rtl/hirq_ctl.sv
module hirq_ctl
   import hirq_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lpc_hw_rst,
   input  logic              lpc_sw_rst,
   input  logic              rd_en,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] rd_data,
   input  logic              obf1,
   input  logic              obf2,
   input  logic              obf3a,
   input  logic              obf3b,
   input  logic              stop_valid,
   input  logic              stop_quiet,
   output logic              hirq1,
   output logic              hirq12,
   output logic              smi
);
   generate
      if (DATA_W < BIT_QUIET + 1) begin : g_bad_width
         $error("hirq_ctl: DATA_W must hold at least 8 bits");
      end
   endgenerate

   localparam int PAD_W = DATA_W - (BIT_QUIET + 1);

   logic               lpc_rst;
   logic [NUM_OBF-1:0] obf_vec;
   logic [NUM_OBF-1:0] obf_fall;
   logic [NUM_EN-1:0]  en;
   logic               direct_q;
   logic               quiet_q;
   logic [NUM_OBF-1:0] obf_eff;

   assign lpc_rst = lpc_hw_rst | lpc_sw_rst;
   assign obf_vec = {obf3b, obf3a, obf2, obf1};

   hirq_obf_edge #(.N(NUM_OBF)) u_edge (
      .clk  (clk),
      .obf  (obf_vec),
      .fall (obf_fall)
   );

   for (genvar i = 0; i < NUM_EN; i++) begin : g_en
      hirq_en_bit #(.ACLR(aclr_kind(i))) u_bit (
         .clk      (clk),
         .rst_n    (rst_n),
         .lpc_rst  (lpc_rst),
         .rd_en    (rd_en),
         .wr_en    (wr_en),
         .wr_bit   (wr_data[i]),
         .obf_fall (obf_fall[obf_src(i)]),
         .direct   (direct_q),
         .en_q     (en[i])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       direct_q <= 1'b0;
      else if (lpc_rst) direct_q <= 1'b0;
      else if (wr_en)   direct_q <= wr_data[BIT_DIR];
   end

   hirq_mode_flag u_mode (
      .clk        (clk),
      .rst_n      (rst_n),
      .lpc_rst    (lpc_rst),
      .stop_valid (stop_valid),
      .stop_quiet (stop_quiet),
      .quiet_q    (quiet_q)
   );

   generate
      if (PAD_W > 0) begin : g_pad
         assign rd_data = {{PAD_W{1'b0}}, quiet_q, 1'b0, direct_q, en};
      end else begin : g_nopad
         assign rd_data = {quiet_q, 1'b0, direct_q, en};
      end
   endgenerate

   // direct mode substitutes 1 for the OBF flag of the SMI sources
   assign obf_eff = obf_vec | {NUM_OBF{direct_q}};

   assign hirq1  = en[0] & obf1;
   assign hirq12 = en[1] & obf1;
   assign smi    = (en[2] & obf_eff[1]) | (en[3] & obf_eff[2]) | (en[4] & obf_eff[3]);

   // R8
   irq1_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hirq1 || hirq12) |-> obf1);
   // R9
   smi_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (smi && !direct_q) |-> (obf2 || obf3a || obf3b));
   // R6
   obf1_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(obf1) && !obf1 && !lpc_rst) |=> !hirq1 && (rd_data[1:0] == 2'b00));
endmodule

// File: tb/hirq_ctl_bench.sv
module hirq_ctl_bench;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       lpc_hw_rst = 1'b0, lpc_sw_rst = 1'b0;
   logic       rd_en = 1'b0, wr_en = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic [7:0] rd_data;
   logic       obf1 = 1'b0, obf2 = 1'b0, obf3a = 1'b0, obf3b = 1'b0;
   logic       stop_valid = 1'b0, stop_quiet = 1'b0;
   logic       hirq1, hirq12, smi;

   int n_chk = 0;
   int n_fail = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   hirq_ctl u_hirq_ctl (
      .clk(clk), .rst_n(rst_n), .lpc_hw_rst(lpc_hw_rst), .lpc_sw_rst(lpc_sw_rst),
      .rd_en(rd_en), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
      .obf1(obf1), .obf2(obf2), .obf3a(obf3a), .obf3b(obf3b),
      .stop_valid(stop_valid), .stop_quiet(stop_quiet),
      .hirq1(hirq1), .hirq12(hirq12), .smi(smi)
   );

   // op: 0 idle, 1 read, 2 write; obf = {3b,3a,2,1}; irq = {smi,hirq12,hirq1}
   typedef struct packed {
      logic [1:0] op;
      logic [7:0] data;
      logic [3:0] obf;
      logic [7:0] exp_reg;
      logic [2:0] exp_irq;
   } vec_t;

   localparam vec_t TBL [16] = '{
      '{2'd2, 8'h01, 4'h0, 8'h00, 3'b000},  // R2 write 1 with no read
      '{2'd1, 8'h00, 4'h0, 8'h00, 3'b000},  // read arms
      '{2'd2, 8'h03, 4'h0, 8'h03, 3'b000},  // R3 set after read
      '{2'd0, 8'h00, 4'h1, 8'h03, 3'b011},  // R8 obf1 high
      '{2'd0, 8'h00, 4'h0, 8'h00, 3'b000},  // R6 obf1 falls
      '{2'd2, 8'h04, 4'h0, 8'h00, 3'b000},  // R3 disarmed by earlier write
      '{2'd1, 8'h00, 4'h0, 8'h00, 3'b000},
      '{2'd2, 8'h24, 4'h0, 8'h24, 3'b100},  // R9 direct: smi without obf
      '{2'd0, 8'h00, 4'h2, 8'h24, 3'b100},
      '{2'd0, 8'h00, 4'h0, 8'h24, 3'b100},  // R7 no clear while direct
      '{2'd2, 8'h20, 4'h0, 8'h20, 3'b000},  // R4 write 0 clears
      '{2'd1, 8'h00, 4'h0, 8'h20, 3'b000},
      '{2'd2, 8'h08, 4'h0, 8'h08, 3'b000},  // R4 direct bit written 0
      '{2'd0, 8'h00, 4'h4, 8'h08, 3'b100},  // R9 obf3a gated
      '{2'd0, 8'h00, 4'h0, 8'h08, 3'b000},  // R7 obf3a fall keeps bit 3
      '{2'd2, 8'hC8, 4'h0, 8'h08, 3'b000}   // R4 bits 7,6 ignored
   };

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic set_obf(input logic [3:0] v);
      {obf3b, obf3a, obf2, obf1} = v;
   endtask

   // one cycle: drive at negedge, the posedge updates, return at next negedge
   task automatic cyc(input logic rd, input logic wr, input logic [7:0] d);
      rd_en = rd; wr_en = wr; wr_data = d;
      @(negedge clk);
      rd_en = 1'b0; wr_en = 1'b0;
   endtask

   task automatic rd_reg();
      cyc(1'b1, 1'b0, 8'h00);
   endtask

   task automatic wr_reg(input logic [7:0] d);
      cyc(1'b0, 1'b1, d);
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
   endtask

   initial begin
      #(CLK_PERIOD * 50000);
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      summary();
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 reg", rd_data, 8'h00);
      chk("R1 irq", {5'd0, smi, hirq12, hirq1}, 8'h00);

      for (int i = 0; i < 16; i++) begin
         set_obf(TBL[i].obf);
         cyc(TBL[i].op == 2'd1, TBL[i].op == 2'd2, TBL[i].data);
         chk($sformatf("table[%0d] reg", i), rd_data, TBL[i].exp_reg);
         chk($sformatf("table[%0d] irq", i), {5'd0, smi, hirq12, hirq1}, {5'd0, TBL[i].exp_irq});
      end

      // R7 obf3b fall clears bit 4 while direct is 0
      set_obf(4'h8);
      rd_reg();
      wr_reg(8'h18);
      chk("R7 3b set", rd_data, 8'h18);
      set_obf(4'h0);
      @(negedge clk);
      chk("R7 3b cleared", rd_data, 8'h08);

      // R7 obf2 fall clears bit 2 while direct is 0
      set_obf(4'h2);
      rd_reg();
      wr_reg(8'h0C);
      set_obf(4'h0);
      @(negedge clk);
      chk("R7 obf2 cleared", rd_data, 8'h08);

      // R11 obf1 falls in the same cycle as a legal set
      set_obf(4'h1);
      rd_reg();
      set_obf(4'h0);
      wr_reg(8'h0B);
      chk("R11 clear wins", rd_data, 8'h08);

      // R10 stop frame mode
      stop_valid = 1'b1; stop_quiet = 1'b1;
      @(negedge clk);
      stop_valid = 1'b0; stop_quiet = 1'b0;
      chk("R10 quiet", rd_data, 8'h88);
      @(negedge clk);
      chk("R10 hold", rd_data, 8'h88);
      stop_valid = 1'b1;
      @(negedge clk);
      stop_valid = 1'b0;
      chk("R10 continuous", rd_data, 8'h08);

      // R5 hardware reset
      stop_valid = 1'b1; stop_quiet = 1'b1;
      @(negedge clk);
      stop_valid = 1'b0; stop_quiet = 1'b0;
      rd_reg();
      wr_reg(8'h2B);
      chk("R5 pre", rd_data, 8'hAB);
      lpc_hw_rst = 1'b1;
      @(negedge clk);
      lpc_hw_rst = 1'b0;
      chk("R5 hw rst", rd_data, 8'h00);

      // R5 software reset clears bits and armed state
      rd_reg();
      wr_reg(8'h01);
      rd_reg();
      lpc_sw_rst = 1'b1;
      @(negedge clk);
      lpc_sw_rst = 1'b0;
      chk("R5 sw rst", rd_data, 8'h00);
      wr_reg(8'h1F);
      chk("R5 arm cleared", rd_data, 8'h00);

      summary();
      $finish;
   end
endmodule